// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit register-based core and a word-wide data memory. It turns one request into an access to a whole word. It forms the effective address from a base register value plus a signed 16-bit displacement, and it drops the two low bits of that address. Stores may be a byte, a halfword or a full word. For a store, the block copies the source data onto every lane that could receive it, and it raises a byte-enable only for the lanes that the access covers. Lanes are numbered in big-endian order: byte offset 0 of a word is its most significant byte.

For a load, the memory returns the addressed word one cycle after the request. The block keeps the size, signedness and byte offset of the request alongside the read. In the next cycle it selects the addressed byte or halfword and extends it to 32 bits, either by sign or by zeros. A fourth size code does not touch memory: it gives a 16-bit constant placed in the upper half of the result. An access whose address is not a multiple of its size is refused. It raises a one-cycle flag, writes nothing and, for a load, returns zero.

Top module: `lane_align_unit`

## Requirements
- R1: The effective address is `base_addr` plus `disp` sign-extended to 32 bits, and `mem_addr` equals that sum with bits 1:0 forced to zero.
- R2: For an aligned store, `mem_be` bit 3 enables data bits 31:24 (byte offset 0), and bit 0 enables bits 7:0 (offset 3). A byte store enables only the lane of its offset. A halfword store at offset 0 gives 4'b1100, at offset 2 it gives 4'b0011, and a word store gives 4'b1111. `mem_we` is high for every aligned store.
- R3: Store write data is replicated across the word: the low byte four times for a byte store, the low halfword twice for a halfword store, and the full value for a word store.
- R4: A request is aligned when its size is byte, or halfword with address bit 0 clear, or word with address bits 1:0 clear. For a misaligned request, `misalign` is high for exactly the following cycle. A misaligned store leaves `mem_be` at 0 and `mem_we` low, so memory is untouched. A misaligned load returns 0.
- R5: A byte load (`req_size` 0) returns the byte at the addressed offset, taken from bits 31-8*offset down to 24-8*offset of the memory word. With `req_unsigned` at 0 it is sign-extended, and with 1 it is zero-extended.
- R6: A halfword load (`req_size` 1) returns bits 31:16 for offset 0 and bits 15:0 for offset 2, sign-extended or zero-extended as `req_unsigned` selects.
- R7: A word load (`req_size` 2) returns the memory word unchanged.
- R8: `req_size` 3 on a load returns `{disp, 16'h0000}` without a memory read. On a store it is never misaligned and writes nothing (`mem_be` is 0).
- R9: `ld_valid` and `ld_data` appear in the cycle after a load request is accepted, and the memory read data must arrive in that same cycle. Store and idle cycles give `ld_valid` low in the cycle after. Back-to-back loads each produce a result in order.
- R10: After synchronous reset, `ld_valid` and `misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 upper-constant |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed displacement / upper constant |
| st_data | input | 32 | Store source data |
| mem_rdata | input | 32 | Word read from memory, one cycle after `mem_re` |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Replicated write data |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Previous request was misaligned |

## Verification
A wrong lane decode shows up at once, in the request cycle, as a wrong `mem_be` or `mem_wdata` pattern. Later it also appears as corrupted neighbouring bytes when the same word is read back. A fault in the held size, offset or sign choice stays hidden until the next cycle, and then `ld_data` is wrong: the wrong byte, or the wrong upper bits after extension. Faults in alignment detection are exposed by the one-cycle flag and by a write that should have been suppressed. Such a write is seen at the ports as a changed word on a later load.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_UPPER = 2'd3
    } acc_size_e;

    typedef struct packed {
        acc_size_e        size;
        logic             uns;
        logic [OFS_W-1:0] ofs;
        logic             bad;
        logic [15:0]      imm;
    } ld_ctrl_t;

    function automatic logic size_aligned(acc_size_e sz, logic [OFS_W-1:0] o);
        case (sz)
            SZ_HALF: return ~o[0];
            SZ_WORD: return o == '0;
            default: return 1'b1;
        endcase
    endfunction

    // does an access of size sz at offset o cover byte offset k
    function automatic logic lane_hit(acc_size_e sz, logic [OFS_W-1:0] o,
                                      logic [OFS_W-1:0] k);
        case (sz)
            SZ_BYTE: return o == k;
            SZ_HALF: return o[1] == k[1];
            SZ_WORD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DISP_W-1:0] disp,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] word_addr,
    output logic [OFS_W-1:0]  ofs,
    output logic              aligned
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] eff;

    always_comb begin
        eff       = base_addr + {{EXT_W{disp[DISP_W-1]}}, disp};
        ofs       = eff[OFS_W-1:0];
        word_addr = {eff[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        aligned   = size_aligned(size, ofs);
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  acc_size_e         size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] sdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    // big-endian: enable bit l serves byte offset LANES-1-l
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [OFS_W-1:0] BOFS = OFS_W'(LANES - 1 - l);
        assign be[l] = en & lane_hit(size, ofs, BOFS);
    end

    always_comb begin
        case (size)
            SZ_BYTE: wdata = {LANES{sdata[7:0]}};
            SZ_HALF: wdata = {(LANES/2){sdata[15:0]}};
            SZ_WORD: wdata = sdata;
            default: wdata = '0;
        endcase
    end

    a_r2_half_lanes_pair: assert property (@(posedge clk) disable iff (rst)
        (en && size == SZ_HALF) |-> (be == 4'b1100 || be == 4'b0011));
    a_r2_byte_single_lane: assert property (@(posedge clk) disable iff (rst)
        (en && size == SZ_BYTE) |-> $onehot0(be) && be != '0);
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_load,
    input  logic              take_bad,
    input  ld_ctrl_t          ctrl_d,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              misalign
);
    ld_ctrl_t ctrl_q;
    logic     vld_q;
    logic     bad_q;
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            bad_q  <= 1'b0;
            ctrl_q <= '0;
        end else begin
            vld_q  <= take_load;
            bad_q  <= take_bad;
            if (take_load) ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        sel_b = mem_rdata[8*(LANES-1-int'(ctrl_q.ofs)) +: 8];
        sel_h = ctrl_q.ofs[1] ? mem_rdata[15:0] : mem_rdata[31:16];
        if (ctrl_q.bad) ld_data = '0;
        else case (ctrl_q.size)
            SZ_BYTE: ld_data = {{(DATA_W-8){sel_b[7] & ~ctrl_q.uns}}, sel_b};
            SZ_HALF: ld_data = {{(DATA_W-16){sel_h[15] & ~ctrl_q.uns}}, sel_h};
            SZ_WORD: ld_data = mem_rdata;
            default: ld_data = {ctrl_q.imm, 16'h0000};
        endcase
    end

    assign ld_valid = vld_q;
    assign misalign = bad_q;

    a_r4_bad_load_zero: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && misalign) |-> ld_data == '0);
    a_r8_upper_low_clear: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ctrl_q.size == SZ_UPPER) |-> ld_data[15:0] == '0);
    a_r6_half_unsigned_top: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ctrl_q.size == SZ_HALF && ctrl_q.uns) |-> ld_data[31:16] == '0);
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DISP_W-1:0] disp,
    input  logic [31:0]       st_data,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    output logic              mem_we,
    output logic              mem_re,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic              misalign
);
    acc_size_e        size;
    logic [OFS_W-1:0] ofs;
    logic             aligned;
    logic             touches_mem;
    ld_ctrl_t         ctrl;

    assign size        = acc_size_e'(req_size);
    assign touches_mem = req_valid & aligned & (size != SZ_UPPER);

    lsa_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
        .base_addr(base_addr), .disp(disp), .size(size),
        .word_addr(mem_addr), .ofs(ofs), .aligned(aligned));

    lsa_store_lanes u_st (
        .clk(clk), .rst(rst), .en(touches_mem & req_store),
        .size(size), .ofs(ofs), .sdata(st_data),
        .be(mem_be), .wdata(mem_wdata));

    assign mem_we = touches_mem & req_store;
    assign mem_re = touches_mem & ~req_store;

    always_comb begin
        ctrl.size = size;
        ctrl.uns  = req_unsigned;
        ctrl.ofs  = ofs;
        ctrl.bad  = ~aligned;
        ctrl.imm  = disp[15:0];
    end

    lsa_load_extract u_ld (
        .clk(clk), .rst(rst),
        .take_load(req_valid & ~req_store),
        .take_bad(req_valid & ~aligned),
        .ctrl_d(ctrl), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .misalign(misalign));

    a_r9_load_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store) |=> ld_valid);
    a_r9_store_no_result: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store) |=> !ld_valid);
    a_r4_misaligned_store_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store && !aligned) |-> (!mem_we && mem_be == '0));
    a_r4_flag_only_after_request: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !misalign);
    a_r2_we_has_lanes: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_be != '0);
endmodule

// File: tb/test_lane_align_unit.sv
module test_lane_align_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] base_addr = '0, st_data = '0;
    logic [15:0] disp = '0;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;
    logic        mem_we, mem_re, ld_valid, misalign;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lane_align_unit i_lane_align_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .base_addr(base_addr),
        .disp(disp), .st_data(st_data), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_we(mem_we), .mem_re(mem_re), .ld_valid(ld_valid),
        .ld_data(ld_data), .misalign(misalign));

    // synchronous memory in the bench
    logic [31:0] ram [0:15];
    logic [31:0] rd_q = '0;
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (mem_we)
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) ram[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        rd_q <= ram[mem_addr[5:2]];
    end

    logic [31:0] model [0:15];

    typedef struct { bit ld; bit mis; logic [31:0] d; } item_t;
    item_t sb[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        sb.push_back('{0, 0, 32'h0});
    endtask

    task automatic req(bit st, logic [1:0] sz, bit uns, logic [31:0] b,
                       logic [15:0] d, logic [31:0] sd);
        logic [31:0] ea, w, ex;
        logic [1:0]  o;
        logic [3:0]  ebe;
        bit          al;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
        base_addr = b; disp = d; st_data = sd;
        #1;
        ea = b + {{16{d[15]}}, d};
        o  = ea[1:0];
        al = (sz == 2'd1) ? (o[0] == 1'b0) : (sz == 2'd2) ? (o == 2'd0) : 1'b1;
        if (sz != 2'd3) chk("R1 addr", mem_addr, {ea[31:2], 2'b00});
        if (st) begin
            ebe = 4'b0000;
            if (al) case (sz)
                2'd0: ebe = 4'b1000 >> o;
                2'd1: ebe = o[1] ? 4'b0011 : 4'b1100;
                2'd2: ebe = 4'b1111;
                default: ebe = 4'b0000;
            endcase
            chk(al ? "R2 be" : "R4 be", {28'h0, mem_be}, {28'h0, ebe});
            chk(al ? "R2 we" : "R4 we", {31'h0, mem_we}, {31'h0, ebe != 0});
            if (al && sz == 2'd0) chk("R3 wdata", mem_wdata, {4{sd[7:0]}});
            if (al && sz == 2'd1) chk("R3 wdata", mem_wdata, {2{sd[15:0]}});
            if (al && sz == 2'd2) chk("R3 wdata", mem_wdata, sd);
            for (int l = 0; l < 4; l++)
                if (ebe[l]) model[ea[5:2]][8*l +: 8] = mem_wdata[8*l +: 8];
            sb.push_back('{0, !al, 32'h0});
        end else begin
            w = model[ea[5:2]];
            case (sz)
                2'd0: begin ex = (w >> (8 * (3 - o))) & 32'hFF;
                            if (!uns && ex[7]) ex |= 32'hFFFF_FF00; end
                2'd1: begin ex = o[1] ? (w & 32'hFFFF) : (w >> 16);
                            if (!uns && ex[15]) ex |= 32'hFFFF_0000; end
                2'd2: ex = w;
                default: ex = {d, 16'h0};
            endcase
            if (!al) ex = 32'h0;
            sb.push_back('{1, !al, ex});
        end
    endtask

    // monitor: compares each accepted item one cycle later
    initial begin
        @(negedge clk);
        while (!done) begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk("R9 ld_valid", {31'h0, ld_valid}, {31'h0, it.ld});
                chk("R4 misalign", {31'h0, misalign}, {31'h0, it.mis});
                if (it.ld) chk("R5/R6/R7/R8 ld_data", ld_data, it.d);
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin ram[i] = 32'h0; model[i] = 32'h0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 ld_valid", {31'h0, ld_valid}, 32'h0);
        chk("R10 misalign", {31'h0, misalign}, 32'h0);
        // R1 negative displacement, word store
        req(1, 2'd2, 0, 32'h10, 16'hFFF4, 32'h8123_45F6);
        // R2/R3 byte stores at each offset into word 2
        for (int k = 0; k < 4; k++) req(1, 2'd0, 0, 32'h8, 16'(k), 32'h0000_0090 + k);
        // half stores
        req(1, 2'd1, 0, 32'hC, 16'h0, 32'h0000_A5C3);
        req(1, 2'd1, 0, 32'hC, 16'h2, 32'h0000_7E11);
        // R4 misaligned stores do nothing
        req(1, 2'd1, 0, 32'h4, 16'h1, 32'hFFFF_FFFF);
        req(1, 2'd2, 0, 32'h4, 16'h2, 32'hFFFF_FFFF);
        // R8 upper-constant store writes nothing
        req(1, 2'd3, 0, 32'h4, 16'h0, 32'hFFFF_FFFF);
        idle();
        // R7 word read back (also shows the misaligned stores had no effect)
        req(0, 2'd2, 0, 32'h4, 16'h0, 0);
        // R5 byte loads, signed and unsigned, back to back
        for (int k = 0; k < 4; k++) begin
            req(0, 2'd0, 0, 32'h4, 16'(k), 0);
            req(0, 2'd0, 1, 32'h4, 16'(k), 0);
        end
        req(0, 2'd0, 0, 32'h8, 16'h3, 0);
        // R6 half loads
        req(0, 2'd1, 0, 32'hC, 16'h0, 0);
        req(0, 2'd1, 1, 32'hC, 16'h0, 0);
        req(0, 2'd1, 0, 32'hC, 16'h2, 0);
        req(0, 2'd1, 0, 32'h4, 16'h2, 0);
        req(0, 2'd1, 1, 32'h4, 16'h2, 0);
        // R8 upper constant
        req(0, 2'd3, 0, 32'h0, 16'hBEEF, 0);
        // R4 misaligned loads return zero
        req(0, 2'd1, 0, 32'h4, 16'h3, 0);
        req(0, 2'd2, 1, 32'h4, 16'h1, 0);
        idle();
        idle();
        idle();
        done = 1;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule